// File: doc/BRIEF.md
# Superscalar Issue Port Allocator

This block sits in a four-wide, in-order issue stage. Each cycle it looks at up to four decoded instruction slots, given in program order. Each slot has a class code, a valid bit and an operand-ready bit. The block places each slot on one of six function units: two load/store pipes, two integer execute pipes and two floating-point pipes. It issues the longest leading run of slots that can all be placed under the unit rules. The slot that fails and every slot after it are held back for a later cycle.

Units are handed out in a fixed preference order. The integer and floating-point pipe of each side share an issue port, so they cannot both be granted in the same cycle. Stores claim two units at once. Several classes are tied to one particular pipe. The second floating-point pipe is available only when floating-point exceptions are off and wide floating-point mode is on.

The result is registered. One cycle after the inputs are presented, the outputs give a per-slot issue flag, the main unit index for each slot, a companion unit index for stores, and a grant mask of the units in use.

Top module: `issue_port_alloc`

## Requirements
- R1: While reset is held, every issue flag is 0, every unit and companion index reads 7 (none), and the grant mask is zero.
- R2: Outputs are registered. The placement for the inputs sampled at one rising edge appears after that edge and holds until the next edge.
- R3: Issue is an in-order prefix. The first slot that is not valid, not ready, or cannot be placed is not issued, and no later slot is issued in that cycle.
- R4: Unit codes are ls0=0, ls1=1, ex0=2, ex1=3, fp0=4, fp1=5, all=6, none=7. The grant mask bit of a unit is at the position of its code. A unit is never granted twice, and ex0/fp0 and ex1/fp1 are never granted together. The only exception is the all-units grant of R12.
- R5: A general ALU op (class 1) takes ex1, else ex0.
- R6: A plain load (class 4) takes ls0, else ls1. An indexed load or prefetch (class 5) takes only ls1.
- R7: A simple ALU op (class 0) takes ls1 if ls1 is free and no load (class 4 or 5) was issued earlier in the same cycle. Otherwise it takes ex1, then ex0.
- R8: An integer store (class 6) takes an LS unit plus an EX unit. An FP store (class 7) takes an LS unit plus an FP unit. An indexed FP store (class 8) takes ls1 plus an FP unit. The LS side prefers ls0, the EX side prefers ex1 and the FP side prefers fp1. The LS unit is reported as the unit index and the other unit as the companion index; for all other classes the companion index is 7.
- R9: Set-less-than/count-leading-zeros/trap ops (class 2) and branches, jumps and calls (class 3) take only ex0.
- R10: HI/LO moves (class 11), multiplies (class 12) and divides (class 13) take only ex1.
- R11: An FP execute op (class 9) takes fp1. It may fall back to fp0 only when the exception input is low and the wide-FP input is high. An FP compare (class 10) takes only fp1.
- R12: An unknown-class op (class 14 or 15) needs all six units free. It issues only as the first slot, reports unit 6 and a full grant mask, and stops every later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid | input | SLOTS | Slot holds an instruction; bit 0 is oldest |
| slot_ready | input | SLOTS | Operands of the slot are available |
| slot_class | input | SLOTS*CLASS_W | Class code per slot; slot s at bits [s*CLASS_W +: CLASS_W] |
| fp_exc_on | input | 1 | Floating-point exceptions enabled |
| fp_wide | input | 1 | 64-bit floating-point register mode |
| iss_go | output | SLOTS | Slot issued this cycle |
| iss_unit | output | SLOTS*UNIT_W | Main unit code per slot |
| iss_aux | output | SLOTS*UNIT_W | Companion unit code per slot (stores) |
| iss_busy | output | 6 | Grant mask of units in use |

## Verification
The bench targets the places where the preference order and the pair exclusion interact. One case is an ALU op that must slide to ex0 because an FP store took fp1; a design that ignored the exclusion would double-book the ex1/fp1 port. Another is a second FP store that finds fp0 blocked by that same ex0 and must stall; a wrong design would issue it anyway. Simple ALU ops are placed both with and without an earlier load, which catches a design that always steers them to ls1. FP execute ops are driven under all three mode combinations, which catches a design that opens fp0 when exceptions are on. Unknown ops are placed first and second, to catch a design that lets them share the cycle. Stalls from not-ready and invalid slots are also driven, to catch a design that lets a younger slot overtake a blocked one.

// File: rtl/issue_alloc_pkg.sv
package issue_alloc_pkg;

   localparam int NUM_UNITS = 6;

   // unit codes double as grant-mask bit positions
   localparam logic [2:0] U_LS0  = 3'd0;
   localparam logic [2:0] U_LS1  = 3'd1;
   localparam logic [2:0] U_EX0  = 3'd2;
   localparam logic [2:0] U_EX1  = 3'd3;
   localparam logic [2:0] U_FP0  = 3'd4;
   localparam logic [2:0] U_FP1  = 3'd5;
   localparam logic [2:0] U_ALL  = 3'd6;
   localparam logic [2:0] U_NONE = 3'd7;

   localparam int IX_LS0 = 0;
   localparam int IX_LS1 = 1;
   localparam int IX_EX0 = 2;
   localparam int IX_EX1 = 3;
   localparam int IX_FP0 = 4;
   localparam int IX_FP1 = 5;

   typedef enum logic [3:0] {
      CL_SALU  = 4'd0,
      CL_ALU   = 4'd1,
      CL_EX0OP = 4'd2,
      CL_BR    = 4'd3,
      CL_LD    = 4'd4,
      CL_LDX   = 4'd5,
      CL_ST    = 4'd6,
      CL_FST   = 4'd7,
      CL_FSTX  = 4'd8,
      CL_FOP   = 4'd9,
      CL_FCMP  = 4'd10,
      CL_HILO  = 4'd11,
      CL_MUL   = 4'd12,
      CL_DIV   = 4'd13,
      CL_UNK   = 4'd14
   } iclass_e;

   function automatic logic [NUM_UNITS-1:0] unit_bit(input logic [2:0] u);
      logic [NUM_UNITS-1:0] m;
      m = '0;
      if (int'(u) < NUM_UNITS) m[u] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/issue_slot_pick.sv
module issue_slot_pick
   import issue_alloc_pkg::*;
#(
   parameter int CLASS_W = 4,
   parameter int UNIT_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CLASS_W-1:0]   in_cls,
   input  logic                 in_valid,
   input  logic                 in_ready,
   input  logic                 prior_ok,
   input  logic                 load_seen,
   input  logic                 two_fp,
   input  logic [NUM_UNITS-1:0] busy_in,
   output logic                 take,
   output logic [UNIT_W-1:0]    unit,
   output logic [UNIT_W-1:0]    aux,
   output logic [NUM_UNITS-1:0] busy_out,
   output logic                 load_seen_out
);

   iclass_e              cls;
   logic [NUM_UNITS-1:0] fr;
   logic                 hit;
   logic                 grab_all;
   logic [2:0]           u_sel;
   logic [2:0]           a_sel;
   logic [2:0]           ls_pick;
   logic [2:0]           ex_pick;
   logic [2:0]           fp_pick;
   logic [NUM_UNITS-1:0] claim;

   assign cls = iclass_e'(in_cls[3:0]);

   // a shared-port unit is free only if its partner is idle too
   always_comb begin
      fr[IX_LS0] = !busy_in[IX_LS0];
      fr[IX_LS1] = !busy_in[IX_LS1];
      fr[IX_EX0] = !busy_in[IX_EX0] && !busy_in[IX_FP0];
      fr[IX_EX1] = !busy_in[IX_EX1] && !busy_in[IX_FP1];
      fr[IX_FP0] = !busy_in[IX_FP0] && !busy_in[IX_EX0];
      fr[IX_FP1] = !busy_in[IX_FP1] && !busy_in[IX_EX1];
   end

   // side pickers in preference order
   always_comb begin
      ls_pick = fr[IX_LS0] ? U_LS0 : (fr[IX_LS1] ? U_LS1 : U_NONE);
      ex_pick = fr[IX_EX1] ? U_EX1 : (fr[IX_EX0] ? U_EX0 : U_NONE);
      fp_pick = fr[IX_FP1] ? U_FP1 : (fr[IX_FP0] ? U_FP0 : U_NONE);
   end

   always_comb begin
      hit      = 1'b0;
      grab_all = 1'b0;
      u_sel    = U_NONE;
      a_sel    = U_NONE;
      case (cls)
         CL_SALU: begin
            if (fr[IX_LS1] && !load_seen) u_sel = U_LS1;
            else                          u_sel = ex_pick;
            hit = (u_sel != U_NONE);
         end
         CL_ALU: begin
            u_sel = ex_pick;
            hit   = (u_sel != U_NONE);
         end
         CL_EX0OP, CL_BR: begin
            hit   = fr[IX_EX0];
            u_sel = U_EX0;
         end
         CL_LD: begin
            u_sel = ls_pick;
            hit   = (u_sel != U_NONE);
         end
         CL_LDX: begin
            hit   = fr[IX_LS1];
            u_sel = U_LS1;
         end
         CL_ST: begin
            u_sel = ls_pick;
            a_sel = ex_pick;
            hit   = (ls_pick != U_NONE) && (ex_pick != U_NONE);
         end
         CL_FST: begin
            u_sel = ls_pick;
            a_sel = fp_pick;
            hit   = (ls_pick != U_NONE) && (fp_pick != U_NONE);
         end
         CL_FSTX: begin
            u_sel = U_LS1;
            a_sel = fp_pick;
            hit   = fr[IX_LS1] && (fp_pick != U_NONE);
         end
         CL_FOP: begin
            if (fr[IX_FP1])               u_sel = U_FP1;
            else if (two_fp && fr[IX_FP0]) u_sel = U_FP0;
            hit = (u_sel != U_NONE);
         end
         CL_FCMP: begin
            hit   = fr[IX_FP1];
            u_sel = U_FP1;
         end
         CL_HILO, CL_MUL, CL_DIV: begin
            hit   = fr[IX_EX1];
            u_sel = U_EX1;
         end
         default: begin
            grab_all = 1'b1;
            hit      = (busy_in == '0);
            u_sel    = U_ALL;
         end
      endcase
   end

   assign take  = prior_ok && in_valid && in_ready && hit;
   assign claim = grab_all ? {NUM_UNITS{1'b1}} : (unit_bit(u_sel) | unit_bit(a_sel));

   assign busy_out      = take ? (busy_in | claim) : busy_in;
   assign unit          = take ? UNIT_W'(u_sel) : UNIT_W'(U_NONE);
   assign aux           = take ? UNIT_W'(a_sel) : UNIT_W'(U_NONE);
   assign load_seen_out = load_seen || (take && (cls == CL_LD || cls == CL_LDX));

   // R9
   ex0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (cls == CL_EX0OP || cls == CL_BR)) |-> (unit == UNIT_W'(U_EX0)));

   // R10
   ex1_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (cls == CL_HILO || cls == CL_MUL || cls == CL_DIV)) |-> (unit == UNIT_W'(U_EX1)));

   // R11
   fp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (cls == CL_FCMP || (cls == CL_FOP && !two_fp))) |-> (unit == UNIT_W'(U_FP1)));

   // R6
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == CL_LDX) |-> (unit == UNIT_W'(U_LS1)));

   // R4
   claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((busy_out & busy_in) == busy_in) && (busy_out != busy_in));

endmodule

// File: rtl/issue_grant_reg.sv
module issue_grant_reg #(
   parameter int SLOTS  = 4,
   parameter int UNIT_W = 3,
   parameter int NU     = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SLOTS-1:0]        d_go,
   input  logic [SLOTS*UNIT_W-1:0] d_unit,
   input  logic [SLOTS*UNIT_W-1:0] d_aux,
   input  logic [NU-1:0]           d_busy,
   output logic [SLOTS-1:0]        q_go,
   output logic [SLOTS*UNIT_W-1:0] q_unit,
   output logic [SLOTS*UNIT_W-1:0] q_aux,
   output logic [NU-1:0]           q_busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_go   <= '0;
         q_unit <= '1;
         q_aux  <= '1;
         q_busy <= '0;
      end else begin
         q_go   <= d_go;
         q_unit <= d_unit;
         q_aux  <= d_aux;
         q_busy <= d_busy;
      end
   end

endmodule

// File: rtl/issue_port_alloc.sv
module issue_port_alloc
   import issue_alloc_pkg::*;
#(
   parameter int SLOTS      = 4,
   parameter int CLASS_W    = 4,
   parameter int UNIT_W     = 3,
   parameter bit FP_DUAL_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [SLOTS-1:0]         slot_valid,
   input  logic [SLOTS-1:0]         slot_ready,
   input  logic [SLOTS*CLASS_W-1:0] slot_class,
   input  logic                     fp_exc_on,
   input  logic                     fp_wide,
   output logic [SLOTS-1:0]         iss_go,
   output logic [SLOTS*UNIT_W-1:0]  iss_unit,
   output logic [SLOTS*UNIT_W-1:0]  iss_aux,
   output logic [NUM_UNITS-1:0]     iss_busy
);

   localparam int LINKS = SLOTS + 1;

   generate
      if (SLOTS < 1 || SLOTS > 8) begin : g_bad_slots
         $error("issue_port_alloc: SLOTS must lie in 1..8");
      end
      if (CLASS_W != 4) begin : g_bad_class
         $error("issue_port_alloc: CLASS_W must be 4");
      end
      if (UNIT_W != 3) begin : g_bad_unit
         $error("issue_port_alloc: UNIT_W must be 3");
      end
   endgenerate

   logic                 two_fp;
   logic [NUM_UNITS-1:0] busy_chain [LINKS];
   logic [LINKS-1:0]     ok_chain;
   logic [LINKS-1:0]     ld_chain;
   logic [SLOTS-1:0]         nx_go;
   logic [SLOTS*UNIT_W-1:0]  nx_unit;
   logic [SLOTS*UNIT_W-1:0]  nx_aux;

   generate
      if (FP_DUAL_EN) begin : g_fp_dual
         assign two_fp = !fp_exc_on && fp_wide;
      end else begin : g_fp_single
         assign two_fp = 1'b0;
      end
   endgenerate

   assign busy_chain[0] = '0;
   assign ok_chain[0]   = 1'b1;
   assign ld_chain[0]   = 1'b0;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         issue_slot_pick #(
            .CLASS_W (CLASS_W),
            .UNIT_W  (UNIT_W)
         ) u_pick (
            .clk           (clk),
            .rst_n         (rst_n),
            .in_cls        (slot_class[s*CLASS_W +: CLASS_W]),
            .in_valid      (slot_valid[s]),
            .in_ready      (slot_ready[s]),
            .prior_ok      (ok_chain[s]),
            .load_seen     (ld_chain[s]),
            .two_fp        (two_fp),
            .busy_in       (busy_chain[s]),
            .take          (ok_chain[s+1]),
            .unit          (nx_unit[s*UNIT_W +: UNIT_W]),
            .aux           (nx_aux[s*UNIT_W +: UNIT_W]),
            .busy_out      (busy_chain[s+1]),
            .load_seen_out (ld_chain[s+1])
         );
         assign nx_go[s] = ok_chain[s+1];
      end
   endgenerate

   issue_grant_reg #(
      .SLOTS  (SLOTS),
      .UNIT_W (UNIT_W),
      .NU     (NUM_UNITS)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_go   (nx_go),
      .d_unit (nx_unit),
      .d_aux  (nx_aux),
      .d_busy (busy_chain[SLOTS]),
      .q_go   (iss_go),
      .q_unit (iss_unit),
      .q_aux  (iss_aux),
      .q_busy (iss_busy)
   );

   // R3
   prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_go & (iss_go + SLOTS'(1))) == '0);

   // R4
   pair0_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_busy[IX_EX0] && iss_busy[IX_FP0]) |-> ($countones(iss_busy) == NUM_UNITS));

   // R4
   pair1_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_busy[IX_EX1] && iss_busy[IX_FP1]) |-> ($countones(iss_busy) == NUM_UNITS));

   // R4
   width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(iss_busy) <= 4) || (iss_busy == '1));

   // R12
   alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_busy == '1) |-> (iss_go == SLOTS'(1)));

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
         // R3
         ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_go[s] |-> $past(slot_valid[s] && slot_ready[s]));
         // R4
         named_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_go[s] == (iss_unit[s*UNIT_W +: UNIT_W] != UNIT_W'(U_NONE)));
         for (genvar t = s + 1; t < SLOTS; t++) begin : g_pair
            // R4
            no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (iss_go[s] && iss_go[t]) |->
                  (iss_unit[s*UNIT_W +: UNIT_W] != iss_unit[t*UNIT_W +: UNIT_W]));
         end
      end
   endgenerate

endmodule

// File: tb/issue_port_alloc_test.sv
module issue_port_alloc_test;
   import issue_alloc_pkg::*;

   localparam int SLOTS = 4;
   localparam int CW    = 4;
   localparam int UW    = 3;

   localparam int C_SALU = 0,  C_ALU = 1,  C_EX0 = 2,  C_BR = 3;
   localparam int C_LD = 4,    C_LDX = 5,  C_ST = 6,   C_FST = 7;
   localparam int C_FSTX = 8,  C_FOP = 9,  C_FCMP = 10, C_HILO = 11;
   localparam int C_MUL = 12,  C_DIV = 13, C_UNK = 14, C_UNK2 = 15;
   localparam int N = 7;

   typedef struct {
      logic [SLOTS-1:0]    go;
      logic [SLOTS*UW-1:0] unit;
      logic [SLOTS*UW-1:0] aux;
      logic [5:0]          busy;
      string               tag;
   } exp_t;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [SLOTS-1:0]      slot_valid = '0;
   logic [SLOTS-1:0]      slot_ready = '0;
   logic [SLOTS*CW-1:0]   slot_class = '0;
   logic                  fp_exc_on = 1'b1;
   logic                  fp_wide = 1'b0;
   logic [SLOTS-1:0]      iss_go;
   logic [SLOTS*UW-1:0]   iss_unit;
   logic [SLOTS*UW-1:0]   iss_aux;
   logic [5:0]            iss_busy;

   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   issue_port_alloc #(.SLOTS(SLOTS), .CLASS_W(CW), .UNIT_W(UW)) uut (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
      .slot_class(slot_class), .fp_exc_on(fp_exc_on), .fp_wide(fp_wide),
      .iss_go(iss_go), .iss_unit(iss_unit), .iss_aux(iss_aux), .iss_busy(iss_busy)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input int c0, c1, c2, c3, input logic [3:0] v, r,
                        input logic exc, wide, input logic [3:0] eg,
                        input int u0, u1, u2, u3, a0, a1, a2, a3,
                        input logic [5:0] eb, input string tag);
      exp_t e;
      @(negedge clk);
      slot_class = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
      slot_valid = v;
      slot_ready = r;
      fp_exc_on  = exc;
      fp_wide    = wide;
      e.go   = eg;
      e.unit = {UW'(u3), UW'(u2), UW'(u1), UW'(u0)};
      e.aux  = {UW'(a3), UW'(a2), UW'(a1), UW'(a0)};
      e.busy = eb;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   // monitor: results for inputs driven at a falling edge appear after the next rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.tag, "go",   32'(iss_go),   32'(e.go));
            check(e.tag, "unit", 32'(iss_unit), 32'(e.unit));
            check(e.tag, "aux",  32'(iss_aux),  32'(e.aux));
            check(e.tag, "mask", 32'(iss_busy), 32'(e.busy));
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check("R1", "go",   32'(iss_go),   32'h0);
      check("R1", "unit", 32'(iss_unit), 32'hfff);
      check("R1", "aux",  32'(iss_aux),  32'hfff);
      check("R1", "mask", 32'(iss_busy), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 R2: ALU ops fill ex1 then ex0, third stalls, one cycle after drive
      drive(C_ALU, C_ALU, C_ALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0011,
            3, 2, N, N, N, N, N, N, 6'b001100, "R5");
      // R6 plain loads ls0 then ls1
      drive(C_LD, C_LD, C_LD, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0011,
            0, 1, N, N, N, N, N, N, 6'b000011, "R6");
      // R6 indexed load only ls1
      drive(C_LDX, C_LDX, C_ALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0001,
            1, N, N, N, N, N, N, N, 6'b000010, "R6");
      drive(C_LD, C_LDX, C_ALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b1111,
            0, 1, 3, 2, N, N, N, N, 6'b001111, "R6");
      drive(C_LDX, C_LD, C_BR, C_MUL, 4'hf, 4'hf, 1, 0, 4'b1111,
            1, 0, 2, 3, N, N, N, N, 6'b001111, "R6");
      // R7 simple ALU to ls1 then ex1, ex0
      drive(C_SALU, C_SALU, C_SALU, C_SALU, 4'hf, 4'hf, 1, 0, 4'b0111,
            1, 3, 2, N, N, N, N, N, 6'b001110, "R7");
      // R7 earlier load keeps simple ALU off ls1
      drive(C_LD, C_SALU, C_SALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0111,
            0, 3, 2, N, N, N, N, N, 6'b001101, "R7");
      // R8 integer stores pair LS with EX
      drive(C_ST, C_ST, C_ALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0011,
            0, 1, N, N, 3, 2, N, N, 6'b001111, "R8");
      // R8 R7 store then simple ALU on ls1
      drive(C_ST, C_SALU, C_SALU, C_LD, 4'hf, 4'hf, 1, 0, 4'b0111,
            0, 1, 2, N, 3, N, N, N, 6'b001111, "R8");
      // R8 R4 FP store takes fp1, ALU slides to ex0, second FP store blocked
      drive(C_FST, C_ALU, C_FST, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0011,
            0, 2, N, N, 5, N, N, N, 6'b100101, "R8");
      // R8 indexed FP store needs ls1
      drive(C_FSTX, C_FSTX, C_LD, C_LD, 4'hf, 4'hf, 1, 0, 4'b0001,
            1, N, N, N, 5, N, N, N, 6'b100010, "R8");
      // R9 ex0-only classes
      drive(C_BR, C_EX0, C_ALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0001,
            2, N, N, N, N, N, N, N, 6'b000100, "R9");
      // R10 ex1-only classes
      drive(C_MUL, C_DIV, C_ALU, C_ALU, 4'hf, 4'hf, 1, 0, 4'b0001,
            3, N, N, N, N, N, N, N, 6'b001000, "R10");
      drive(C_HILO, C_BR, C_LD, C_LD, 4'hf, 4'hf, 1, 0, 4'b1111,
            3, 2, 0, 1, N, N, N, N, 6'b001111, "R10");
      // R11 exceptions on: fp1 only
      drive(C_FOP, C_FOP, C_ALU, C_ALU, 4'hf, 4'hf, 1, 1, 4'b0001,
            5, N, N, N, N, N, N, N, 6'b100000, "R11");
      // R11 exceptions off and wide: both FP pipes
      drive(C_FOP, C_FOP, C_FOP, C_LD, 4'hf, 4'hf, 0, 1, 4'b0011,
            5, 4, N, N, N, N, N, N, 6'b110000, "R11");
      // R11 exceptions off but narrow: fp1 only
      drive(C_FOP, C_FOP, C_LD, C_LD, 4'hf, 4'hf, 0, 0, 4'b0001,
            5, N, N, N, N, N, N, N, 6'b100000, "R11");
      // R11 compare stays on fp1
      drive(C_FCMP, C_FCMP, C_LD, C_LD, 4'hf, 4'hf, 0, 1, 4'b0001,
            5, N, N, N, N, N, N, N, 6'b100000, "R11");
      drive(C_FCMP, C_FOP, C_ALU, C_LD, 4'hf, 4'hf, 0, 1, 4'b0011,
            5, 4, N, N, N, N, N, N, 6'b110000, "R11");
      // R12 unknown first: all units
      drive(C_UNK, C_ALU, C_LD, C_LD, 4'hf, 4'hf, 1, 0, 4'b0001,
            6, N, N, N, N, N, N, N, 6'b111111, "R12");
      drive(C_UNK2, C_LD, C_LD, C_LD, 4'hf, 4'hf, 0, 1, 4'b0001,
            6, N, N, N, N, N, N, N, 6'b111111, "R12");
      // R12 unknown behind another op cannot issue
      drive(C_ALU, C_UNK, C_LD, C_LD, 4'hf, 4'hf, 1, 0, 4'b0001,
            3, N, N, N, N, N, N, N, 6'b001000, "R12");
      // R3 not-ready slot blocks younger ones
      drive(C_ALU, C_ALU, C_LD, C_LD, 4'hf, 4'b1101, 1, 0, 4'b0001,
            3, N, N, N, N, N, N, N, 6'b001000, "R3");
      // R3 invalid slot ends the group
      drive(C_ALU, C_ALU, C_LD, C_LD, 4'b1101, 4'hf, 1, 0, 4'b0001,
            3, N, N, N, N, N, N, N, 6'b001000, "R3");
      drive(C_LD, C_LD, C_LD, C_LD, 4'hf, 4'b1110, 1, 0, 4'b0000,
            N, N, N, N, N, N, N, N, 6'b000000, "R3");

      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule